// File: doc/BRIEF.md
# Multi-Channel PWM Timer

A small timer peripheral with a 16-bit register interface. It holds a parameterized number of independent counter channels and a single start register shared by all of them, in which each channel owns one run bit. Each channel divides the system clock by a selectable prescale ratio, advances its counter once per divided tick, and compares the counter against general compare registers. In pulse-width mode, the channel drives one output pin. The pin is low from the counter clear until compare A matches, then high until compare B matches. The compare B match also returns the counter to zero, so compare B sets the period and compare A sets the duty cycle.

Software programs a channel while it is stopped. It writes the control, mode and output-control registers, loads the two compare registers and the counter, and then sets the channel's bit in the start register. Clearing that bit freezes the counter and the pin. A sticky status register records compare A and compare B matches until software clears them. Reads are combinational from the address; writes take effect on the clock edge of the write cycle.

Top module: `pwm_timer_unit`

## Requirements
- R1: The start register sits at byte address 0x000. Bit n runs channel n while set. A read returns the run bits zero-extended, and all run bits are 0 after reset.
- R2: Channel n occupies the 64-byte window at 0x040 + 0x040*n. Its registers are 16 bits wide, one per 4 bytes, at these offsets: control 0x00, mode 0x04, output control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, compare A 0x18, compare B 0x1C, compare C 0x20 and compare D 0x24. Interrupt enable and compares C and D are plain storage that reads back what was written. Every register resets to 0.
- R3: Control bits [1:0] = 0, 1, 2, 3 make a running counter advance once every 1, 4, 16 or 64 clocks. The divider restarts from zero each time the channel is started.
- R4: Control bits [7:5] = 3'b010 (control value 0x0040 with prescale 1) return the counter to 0 on the advance taken while it equals compare B. Any other value of bits [7:5] lets the counter run through 0xFFFF to 0x0000.
- R5: With mode bits [3:0] = 2 and output-control bits [3:0] = 2, a running channel drives its pin high exactly when compare A < compare B and counter >= compare A. The pin lags the counter by one clock. The period is (B+1)*div clocks, with (B-A+1)*div of them high. A running channel in any other configuration drives its pin low.
- R6: In the R5 configuration, compare A = 0 keeps the pin high for the whole period, and compare A >= compare B keeps it low.
- R7: While a channel's run bit is clear, its counter and its pin keep their values.
- R8: A counter write takes effect only while the channel is stopped; a write while running is ignored.
- R9: Status bit 0 is set by each compare A match and bit 1 by each compare B match; a match is an advance taken while the counter equals the compare value. Both bits are sticky. Writing 1 to a bit clears it, and a match in the same cycle wins.
- R10: Reads of unmapped or misaligned addresses return 0, and the read data is 0 in any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pwm_out | output | 3 | One pulse-width output per channel |

## Verification
The cycle-by-cycle assertions cover the following:
- Loading the start register from write data.
- Freezing a stopped channel's counter and pin unless software writes the counter.
- Limiting a running counter to hold, step by one or return to zero, which catches a counter write slipping through while running.
- Keeping status flags sticky, and allowing a flag to rise only after a running cycle.

Duty-cycle and period figures for each prescale ratio, the compare A = 0 and A >= B extremes, exact advance counts, wrap-around without clearing, write-one-to-clear, and register read-back are shown only by the bench's scenarios.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

   // Register slots inside one channel window (word index = byte offset / 4)
   typedef enum logic [3:0] {
      RI_CTRL = 4'd0,
      RI_MODE = 4'd1,
      RI_IOC  = 4'd2,
      RI_IEN  = 4'd3,
      RI_STAT = 4'd4,
      RI_CNT  = 4'd5,
      RI_CMPA = 4'd6,
      RI_CMPB = 4'd7,
      RI_CMPC = 4'd8,
      RI_CMPD = 4'd9
   } reg_idx_e;

   localparam int unsigned REG_COUNT = 10;
   localparam logic [3:0]  IDX_NONE  = 4'hF;

   // Field encodings
   localparam logic [2:0] CLR_SRC_CMPB = 3'b010;
   localparam logic [3:0] MODE_PWM     = 4'h2;
   localparam logic [3:0] IOC_LO_HI    = 4'h2;

endpackage

// File: rtl/pwmt_prescale.sv
`timescale 1ns/1ps
module pwmt_prescale #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int unsigned PRE_W = ((1 << SEL_W) - 1) * STEP_LOG2;
   localparam int          STEP  = STEP_LOG2;

   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("pwmt_prescale: STEP_LOG2 must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   // terminal count = 2**(sel*STEP) - 1, built as a run of low ones
   always_comb begin
      for (int b = 0; b < int'(PRE_W); b++) begin
         lim[b] = (b < int'(sel) * STEP);
      end
   end

   assign tick = run && (pre_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwmt_channel.sv
`timescale 1ns/1ps
module pwmt_channel
   import pwmt_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PSEL_W    = 2,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [3:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] cnt_o,
   output logic [1:0]        flags_o,
   output logic              pwm_o
);

   localparam int unsigned N_CMP = 4;

   logic [DATA_W-1:0] ctrl_q, mode_q, ioc_q, ien_q, cnt_q;
   logic [DATA_W-1:0] cmp_q [N_CMP];
   logic [1:0]        flag_q;
   logic              pwm_q;
   logic              tick;
   logic              hit_a, hit_b, clr_on_b, pwm_cfg, level;
   logic [1:0]        flag_clr;

   pwmt_prescale #(
      .SEL_W     (PSEL_W),
      .STEP_LOG2 (STEP_LOG2)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (ctrl_q[PSEL_W-1:0]),
      .tick  (tick)
   );

   assign clr_on_b = (ctrl_q[7:5] == CLR_SRC_CMPB);
   assign pwm_cfg  = (mode_q[3:0] == MODE_PWM) && (ioc_q[3:0] == IOC_LO_HI);
   assign hit_a    = tick && (cnt_q == cmp_q[0]);
   assign hit_b    = tick && (cnt_q == cmp_q[1]);
   assign level    = (cmp_q[0] < cmp_q[1]) && (cnt_q >= cmp_q[0]);
   assign flag_clr = (wr_en && wr_idx == RI_STAT) ? wr_data[1:0] : 2'b00;

   // plain configuration storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         ioc_q  <= '0;
         ien_q  <= '0;
         for (int i = 0; i < int'(N_CMP); i++) cmp_q[i] <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            RI_CTRL: ctrl_q   <= wr_data;
            RI_MODE: mode_q   <= wr_data;
            RI_IOC:  ioc_q    <= wr_data;
            RI_IEN:  ien_q    <= wr_data;
            RI_CMPA: cmp_q[0] <= wr_data;
            RI_CMPB: cmp_q[1] <= wr_data;
            RI_CMPC: cmp_q[2] <= wr_data;
            RI_CMPD: cmp_q[3] <= wr_data;
            default: ;
         endcase
      end
   end

   // counter, match flags and output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= '0;
         pwm_q  <= 1'b0;
      end else begin
         if (!run && wr_en && wr_idx == RI_CNT) begin
            cnt_q <= wr_data;
         end else if (tick) begin
            cnt_q <= (hit_b && clr_on_b) ? '0 : cnt_q + 1'b1;
         end
         flag_q <= (flag_q & ~flag_clr) | {hit_b, hit_a};
         if (run) begin
            pwm_q <= pwm_cfg && level;
         end
      end
   end

   always_comb begin
      case (rd_idx)
         RI_CTRL: rd_data = ctrl_q;
         RI_MODE: rd_data = mode_q;
         RI_IOC:  rd_data = ioc_q;
         RI_IEN:  rd_data = ien_q;
         RI_CMPA: rd_data = cmp_q[0];
         RI_CMPB: rd_data = cmp_q[1];
         RI_CMPC: rd_data = cmp_q[2];
         RI_CMPD: rd_data = cmp_q[3];
         default: rd_data = '0;
      endcase
   end

   assign cnt_o   = cnt_q;
   assign flags_o = flag_q;
   assign pwm_o   = pwm_q;

endmodule

// File: rtl/pwm_timer_unit.sv
`timescale 1ns/1ps
module pwm_timer_unit
   import pwmt_pkg::*;
#(
   parameter int unsigned NCH        = 3,
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CH_BASE    = 64,
   parameter int unsigned CH_SHIFT   = 6,
   parameter int unsigned START_ADDR = 0,
   parameter int unsigned PSEL_W     = 2,
   parameter int unsigned STEP_LOG2  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NCH-1:0]    pwm_out
);

   localparam int unsigned      STRIDE   = 1 << CH_SHIFT;
   localparam int               BASE_BLK = CH_BASE >> CH_SHIFT;
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);

   // elaboration-time parameter checks
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("pwm_timer_unit: NCH must lie in 1..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("pwm_timer_unit: DATA_W must be at least 8");
   end
   if (CH_SHIFT < 6) begin : g_bad_shift
      $error("pwm_timer_unit: channel window too small for its registers");
   end
   if (CH_BASE % STRIDE != 0 || CH_BASE <= START_ADDR) begin : g_bad_base
      $error("pwm_timer_unit: CH_BASE must be stride-aligned and above the start register");
   end
   if (CH_BASE + NCH * STRIDE > (1 << ADDR_W)) begin : g_bad_aw
      $error("pwm_timer_unit: ADDR_W too narrow for the channel windows");
   end

   logic [NCH-1:0]             run_q;
   logic [NCH-1:0]             ch_hit, ch_wr;
   logic [NCH-1:0][DATA_W-1:0] ch_rd, ch_cnt;
   logic [NCH-1:0][1:0]        ch_flags;
   logic [CH_SHIFT-1:0]        off;
   logic                       word_ok;
   logic [3:0]                 reg_idx;
   logic                       start_wr;

   assign off      = bus_addr[CH_SHIFT-1:0];
   assign word_ok  = (off[1:0] == 2'b00) && (int'(off[CH_SHIFT-1:2]) < int'(REG_COUNT));
   assign reg_idx  = word_ok ? off[5:2] : IDX_NONE;
   assign start_wr = bus_en && bus_we && (bus_addr == START_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (start_wr) begin
         run_q <= bus_wdata[NCH-1:0];
      end
   end

   for (genvar n = 0; n < int'(NCH); n++) begin : g_ch
      assign ch_hit[n] = bus_en && (int'(bus_addr[ADDR_W-1:CH_SHIFT]) == BASE_BLK + n);
      assign ch_wr[n]  = ch_hit[n] && bus_we;

      pwmt_channel #(
         .DATA_W    (DATA_W),
         .PSEL_W    (PSEL_W),
         .STEP_LOG2 (STEP_LOG2)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_q[n]),
         .wr_en   (ch_wr[n]),
         .wr_idx  (reg_idx),
         .wr_data (bus_wdata),
         .rd_idx  (reg_idx),
         .rd_data (ch_rd[n]),
         .cnt_o   (ch_cnt[n]),
         .flags_o (ch_flags[n]),
         .pwm_o   (pwm_out[n])
      );
   end

   // read path: counter and status come from the observation buses
   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         if (bus_addr == START_A) begin
            bus_rdata = DATA_W'(run_q);
         end
         for (int n = 0; n < int'(NCH); n++) begin
            if (ch_hit[n]) begin
               if (reg_idx == RI_CNT)       bus_rdata = ch_cnt[n];
               else if (reg_idx == RI_STAT) bus_rdata = DATA_W'(ch_flags[n]);
               else                         bus_rdata = ch_rd[n];
            end
         end
      end
   end

endmodule

// File: rtl/pwm_timer_unit_chk.sv
`timescale 1ns/1ps
module pwm_timer_unit_chk #(
   parameter int unsigned NCH        = 3,
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CH_BASE    = 64,
   parameter int unsigned CH_SHIFT   = 6,
   parameter int unsigned START_ADDR = 0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_en,
   input logic                       bus_we,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [NCH-1:0]             start_data,
   input logic [NCH-1:0]             pwm_out,
   input logic [NCH-1:0]             run_q,
   input logic [NCH-1:0][DATA_W-1:0] ch_cnt,
   input logic [NCH-1:0][1:0]        ch_flags
);

   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);

   logic start_wr;
   assign start_wr = bus_en && bus_we && (bus_addr == START_A);

   // R1: a start-register write loads the run bits on the next cycle
   p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (run_q == $past(start_data)));

   for (genvar n = 0; n < int'(NCH); n++) begin : g_chk
      localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CH_BASE + (n << CH_SHIFT) + 20);
      localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CH_BASE + (n << CH_SHIFT) + 16);

      logic cnt_wr, stat_wr;
      assign cnt_wr  = bus_en && bus_we && (bus_addr == CNT_A);
      assign stat_wr = bus_en && bus_we && (bus_addr == STAT_A);

      // R7: a stopped channel freezes its counter and its pin
      p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_q[n] && !cnt_wr) |=> ($stable(ch_cnt[n]) && $stable(pwm_out[n])));

      // R8: a running counter only holds, steps by one or clears
      p_run_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
         run_q[n] |=> ((ch_cnt[n] == $past(ch_cnt[n])) ||
                       (ch_cnt[n] == $past(ch_cnt[n]) + 1'b1) ||
                       (ch_cnt[n] == '0)));

      // R9: match flags rise only after a running cycle
      p_flag_a_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_flags[n][0]) |-> $past(run_q[n]));
      p_flag_b_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_flags[n][1]) |-> $past(run_q[n]));

      // R9: flags stay set unless software writes the status register
      p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((ch_flags[n] != 2'b00) && !stat_wr) |=> ((ch_flags[n] & $past(ch_flags[n])) == $past(ch_flags[n])));
   end

endmodule

bind pwm_timer_unit pwm_timer_unit_chk #(
   .NCH        (NCH),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .CH_BASE    (CH_BASE),
   .CH_SHIFT   (CH_SHIFT),
   .START_ADDR (START_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .start_data (bus_wdata[NCH-1:0]),
   .pwm_out    (pwm_out),
   .run_q      (run_q),
   .ch_cnt     (ch_cnt),
   .ch_flags   (ch_flags)
);

// File: tb/pwm_timer_unit_bench.sv
`timescale 1ns/1ps
module pwm_timer_unit_bench;

   localparam int NCH = 3;

   // {channel, prescale sel, cmp A, cmp B, expected high clocks, expected period}
   localparam logic [71:0] VEC [8] = '{
      {4'd0, 4'd0, 16'd3, 16'd9, 16'd7,   16'd10},
      {4'd1, 4'd1, 16'd2, 16'd5, 16'd16,  16'd24},
      {4'd2, 4'd2, 16'd1, 16'd3, 16'd48,  16'd64},
      {4'd0, 4'd3, 16'd1, 16'd2, 16'd128, 16'd192},
      {4'd1, 4'd0, 16'd0, 16'd7, 16'd8,   16'd8},
      {4'd2, 4'd0, 16'd5, 16'd5, 16'd0,   16'd6},
      {4'd0, 4'd0, 16'd9, 16'd4, 16'd0,   16'd5},
      {4'd2, 4'd1, 16'd4, 16'd7, 16'd16,  16'd32}
   };

   localparam logic [8:0] A_START = 9'h000;
   localparam int O_CTRL = 'h00, O_MODE = 'h04, O_IOC = 'h08, O_IEN = 'h0C, O_STAT = 'h10;
   localparam int O_CNT  = 'h14, O_CMPA = 'h18, O_CMPB = 'h1C, O_CMPC = 'h20, O_CMPD = 'h24;

   logic        clk, rst_n, bus_en, bus_we;
   logic [8:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [NCH-1:0] pwm_out;
   int n_tests, n_fail;
   bit done;

   pwm_timer_unit u_pwm_timer_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [8:0] ca(input int ch, input int off);
      return 9'(64 + 64 * ch + off);
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // callers stand at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [8:0] a, input logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   // run channel ch for exactly n rising edges
   task automatic run_edges(input int ch, input int n);
      wr(A_START, 16'(1 << ch));
      repeat (n - 1) @(negedge clk);
      wr(A_START, 16'h0000);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] d, d2;
      logic        p;
      logic [71:0] v;
      int ch, ps, ea, eb, eh, ep, hi;
      n_tests = 0; n_fail = 0; done = 0;
      rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R1, R2, R5)
      chk("R5 reset pins", 16'(pwm_out), 16'h0000);
      rd(A_START, d);            chk("R1 reset start", d, 16'h0000);
      rd(ca(2, O_CMPD), d);      chk("R2 reset cmpD", d, 16'h0000);
      rd(ca(1, O_CTRL), d);      chk("R2 reset ctrl", d, 16'h0000);

      // R1 start register width
      wr(A_START, 16'hFFFF);
      rd(A_START, d);            chk("R1 start readback", d, 16'h0007);
      wr(A_START, 16'h0000);

      // R2 plain storage
      wr(ca(2, O_IEN),  16'h00A5);
      wr(ca(2, O_CMPC), 16'h1357);
      wr(ca(2, O_CMPD), 16'hBEEF);
      rd(ca(2, O_IEN), d);       chk("R2 ien", d, 16'h00A5);
      rd(ca(2, O_CMPC), d);      chk("R2 cmpC", d, 16'h1357);
      rd(ca(2, O_CMPD), d);      chk("R2 cmpD", d, 16'hBEEF);

      // vector table: duty and period per prescale (R5, R6), flags (R9), clear (R4)
      for (int i = 0; i < 8; i++) begin
         v  = VEC[i];
         ch = int'(v[71:68]); ps = int'(v[67:64]);
         ea = int'(v[63:48]); eb = int'(v[47:32]);
         eh = int'(v[31:16]); ep = int'(v[15:0]);
         wr(A_START, 16'h0000);
         wr(ca(ch, O_CTRL), 16'(16'h0040 | ps));
         wr(ca(ch, O_MODE), 16'h0002);
         wr(ca(ch, O_IOC),  16'h0002);
         wr(ca(ch, O_CMPA), 16'(ea));
         wr(ca(ch, O_CMPB), 16'(eb));
         wr(ca(ch, O_CNT),  16'h0000);
         wr(ca(ch, O_STAT), 16'h0003);
         wr(A_START, 16'(1 << ch));
         repeat (2 * ep) @(negedge clk);
         hi = 0;
         for (int k = 0; k < ep; k++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
         end
         chk((ea == 0 || ea >= eb) ? "R6 high clocks per period" : "R5 high clocks per period",
             16'(hi), 16'(eh));
         wr(A_START, 16'h0000);
         rd(ca(ch, O_STAT), d);
         chk("R9 match flags", d, (ea <= eb) ? 16'h0003 : 16'h0002);
         rd(ca(ch, O_CNT), d);
         chk("R4 counter within period", 16'(d <= 16'(eb)), 16'h0001);
      end

      // R3 prescale advance counts and divider restart
      wr(ca(2, O_CTRL), 16'h0002);
      wr(ca(2, O_CNT),  16'h0000);
      run_edges(2, 160);
      rd(ca(2, O_CNT), d);       chk("R3 div16 count", d, 16'd10);
      wr(ca(2, O_CTRL), 16'h0003);
      wr(ca(2, O_CNT),  16'h0000);
      run_edges(2, 128);
      rd(ca(2, O_CNT), d);       chk("R3 div64 count", d, 16'd2);
      run_edges(2, 63);
      rd(ca(2, O_CNT), d);       chk("R3 divider restart", d, 16'd2);

      // R4 wrap without clear, clear on compare B
      wr(ca(0, O_CTRL), 16'h0000);
      wr(ca(0, O_CMPB), 16'h0003);
      wr(ca(0, O_CNT),  16'hFFFE);
      run_edges(0, 3);
      rd(ca(0, O_CNT), d);       chk("R4 wrap", d, 16'h0001);
      wr(ca(0, O_CTRL), 16'h0040);
      wr(ca(0, O_CNT),  16'h0000);
      run_edges(0, 4);
      rd(ca(0, O_CNT), d);       chk("R4 clear on B", d, 16'h0000);
      run_edges(0, 5);
      rd(ca(0, O_CNT), d);       chk("R4 restart after clear", d, 16'h0001);

      // R7 hold when stopped (also R5 one-clock lag), then R9 write-one-to-clear
      wr(ca(0, O_MODE), 16'h0002);
      wr(ca(0, O_IOC),  16'h0002);
      wr(ca(0, O_CMPA), 16'h0002);
      wr(ca(0, O_CMPB), 16'h0005);
      wr(ca(0, O_CNT),  16'h0000);
      wr(ca(0, O_STAT), 16'h0003);
      run_edges(0, 16);
      rd(ca(0, O_CNT), d);       chk("R7 count at stop", d, 16'd4);
      p = pwm_out[0];            chk("R5 pin at stop", 16'(p), 16'h0001);
      repeat (40) @(negedge clk);
      rd(ca(0, O_CNT), d2);      chk("R7 count held", d2, d);
      chk("R7 pin held", 16'(pwm_out[0]), 16'(p));
      rd(ca(0, O_STAT), d);      chk("R9 both flags", d, 16'h0003);
      wr(ca(0, O_STAT), 16'h0001);
      rd(ca(0, O_STAT), d);      chk("R9 clear A only", d, 16'h0002);
      wr(ca(0, O_STAT), 16'h0002);
      rd(ca(0, O_STAT), d);      chk("R9 clear B", d, 16'h0000);

      // R8 counter write while running is ignored
      wr(ca(1, O_CTRL), 16'h0003);
      wr(ca(1, O_CNT),  16'h0000);
      wr(A_START, 16'h0002);
      wr(ca(1, O_CNT),  16'h1234);
      wr(A_START, 16'h0000);
      rd(ca(1, O_CNT), d);       chk("R8 running write ignored", d, 16'h0000);
      wr(ca(1, O_CNT),  16'h0055);
      rd(ca(1, O_CNT), d);       chk("R8 stopped write", d, 16'h0055);

      // R5 non-PWM configuration drives the pin low (pin was high before)
      chk("R5 pin before mode change", 16'(pwm_out[1]), 16'h0001);
      wr(ca(1, O_MODE), 16'h0000);
      wr(ca(1, O_CTRL), 16'h0040);
      run_edges(1, 5);
      chk("R5 non-PWM pin low", 16'(pwm_out[1]), 16'h0000);

      // R10 unmapped, misaligned and idle reads
      rd(ca(0, 'h28), d);        chk("R10 unmapped offset", d, 16'h0000);
      rd(9'h004, d);             chk("R10 gap below channels", d, 16'h0000);
      rd(ca(0, 'h1A), d);        chk("R10 misaligned", d, 16'h0000);
      bus_addr = ca(0, O_CMPA); bus_en = 1'b0; bus_we = 1'b0;
      #1;
      chk("R10 idle read data", bus_rdata, 16'h0000);
      @(negedge clk);

      done = 1;
      summary();
      $finish;
   end

endmodule